// File: doc/BRIEF.md
# Fenced Store Buffer

This block sits between a core's store port and the write port of a shared memory. A store is taken in immediately and parked in a small local buffer. It reaches memory only later, and entries within one ordering span can leave in any order. Nothing ages an entry out. A store held here can remain invisible to the rest of the system for as long as nothing asks for it to leave.

A one-cycle fence pulse marks an ordering boundary. Every store accepted before the pulse lands in memory before any store accepted after it. The fence itself never produces a memory write. An atomic write request is the only thing that forces the buffer to empty. While it is pending, new stores are held off and the buffer drains one span at a time, oldest span first. Once the buffer is empty, the atomic's own write goes out, and the atomic completes when memory takes that write. A separate enable lets the buffer drain opportunistically when no atomic is waiting. Within a span, a pseudo-random generator picks the next entry, so reordering really occurs.

Top module: `fence_store_buffer`

## Requirements
- R1: After reset, `stReady` is 1, `memValid` is 0 and `atomDone` is 0.
- R2: A store is accepted in any cycle where `stValid` and `stReady` are both high. `stReady` is low whenever all `DEPTH` entries (default 8) hold a store.
- R3: With `idleDrainEn` low and `atomReq` low, no memory write is issued, however long stores stay buffered.
- R4: Pulsing `fenceIn` never produces a memory write by itself.
- R5: Every store accepted before a fence pulse is written to memory before any store accepted after that pulse.
- R6: Every accepted store is written to memory exactly once, with the address and data it was accepted with.
- R7: With `idleDrainEn` high and no atomic pending, the buffer drains to empty when memory accepts writes.
- R8: Once `memValid` is high, `memValid`, `memAddr` and `memData` hold unchanged until a cycle where `memReady` is high.
- R9: While `atomReq` is high, `stReady` is low. The atomic write (`atomAddr`, `atomData`) is issued only when the buffer is empty. `atomDone` is high for exactly the cycle in which memory accepts that write. The requester holds `atomReq` until `atomDone`.
- R10: A pending atomic drains all buffered stores in fence order even when `idleDrainEn` is low, and its own write is the last of them.
- R11: A store accepted in the same cycle as a fence pulse belongs to the span before that fence.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| stValid | input | 1 | Store request valid |
| stReady | output | 1 | Buffer can accept a store |
| stAddr | input | AW | Store address |
| stData | input | DW | Store data |
| fenceIn | input | 1 | One-cycle store fence pulse |
| atomReq | input | 1 | Atomic write request, held until atomDone |
| atomAddr | input | AW | Atomic write address |
| atomData | input | DW | Atomic write data |
| atomDone | output | 1 | Atomic write accepted by memory |
| idleDrainEn | input | 1 | Allow draining with no atomic pending |
| memValid | output | 1 | Memory write request |
| memReady | input | 1 | Memory accepts the write this cycle |
| memAddr | output | AW | Memory write address |
| memData | output | DW | Memory write data |

## Verification
The bench fills the buffer in several spans while draining is disabled. Seeing no write at all shows that entries are retained and that fences are inert, which pure opportunistic draining or a fence that flushes would both break. The same contents are then drained by the idle enable and, separately, by an atomic. A memory whose ready signal stutters pseudo-randomly checks every write log for span order, exactly-once delivery and the atomic coming last. This separates a correct span tracker from one that ignores groups, or that advances before its oldest span is empty. A store that coincides with a fence, followed by an atomic on an empty buffer, tells apart the two possible groupings of that store and confirms that the atomic needs no prior drain.

// File: rtl/sfb_pkg.sv
package sfb_pkg;

  // Strobes from control to datapath
  typedef struct packed {
    logic wrEn;     // write a new entry
    logic clrEn;    // retire the selected entry
    logic atomSel;  // drive the atomic write on the memory port
  } sfbStrobes_t;

  // 16-bit maximal-length LFSR step
  function automatic logic [15:0] lfsrStep(input logic [15:0] s);
    return {s[14:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
  endfunction

endpackage

// File: rtl/sfb_datapath.sv
module sfb_datapath
  import sfb_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int AW    = 16,
  parameter int DW    = 32,
  parameter int IW    = $clog2(DEPTH),
  parameter int GW    = $clog2(DEPTH) + 1
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  sfbStrobes_t                strobes,
  input  logic [IW-1:0]              wrIdx,
  input  logic [GW-1:0]              wrGroup,
  input  logic [IW-1:0]              selIdx,
  input  logic [AW-1:0]              stAddr,
  input  logic [DW-1:0]              stData,
  input  logic [AW-1:0]              atomAddr,
  input  logic [DW-1:0]              atomData,
  output logic [DEPTH-1:0]           validVec,
  output logic [DEPTH-1:0][GW-1:0]   groupVec,
  output logic [AW-1:0]              memAddr,
  output logic [DW-1:0]              memData
);

  logic [AW-1:0] addrQ [DEPTH];
  logic [DW-1:0] dataQ [DEPTH];
  logic [DEPTH-1:0][GW-1:0] groupQ;
  logic [DEPTH-1:0] validQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      validQ <= '0;
    end else begin
      if (strobes.clrEn) validQ[selIdx] <= 1'b0;
      if (strobes.wrEn)  validQ[wrIdx]  <= 1'b1;
    end
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_entry
    always_ff @(posedge clk) begin
      if (strobes.wrEn && wrIdx == IW'(i)) begin
        addrQ[i]  <= stAddr;
        dataQ[i]  <= stData;
        groupQ[i] <= wrGroup;
      end
    end
  end

  assign validVec = validQ;
  assign groupVec = groupQ;

  always_comb begin
    if (strobes.atomSel) begin
      memAddr = atomAddr;
      memData = atomData;
    end else begin
      memAddr = addrQ[selIdx];
      memData = dataQ[selIdx];
    end
  end

  // R2
  free_slot_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.wrEn |-> !validQ[wrIdx]);

  // R6
  retire_live_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.clrEn |-> validQ[selIdx]);

  // R9
  atom_empty_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.atomSel |-> validQ == '0);

endmodule

// File: rtl/sfb_control.sv
module sfb_control
  import sfb_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int IW    = $clog2(DEPTH),
  parameter int GW    = $clog2(DEPTH) + 1
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     stValid,
  input  logic                     fenceIn,
  input  logic                     atomReq,
  input  logic                     idleDrainEn,
  input  logic                     memReady,
  input  logic [DEPTH-1:0]         validVec,
  input  logic [DEPTH-1:0][GW-1:0] groupVec,
  output logic                     stReady,
  output logic                     memValid,
  output logic                     atomDone,
  output sfbStrobes_t              strobes,
  output logic [IW-1:0]            wrIdx,
  output logic [GW-1:0]            wrGroup,
  output logic [IW-1:0]            selIdx
);

  logic [GW-1:0]    curGroup, oldGroup;
  logic             curUsed;
  logic [15:0]      lfsrQ;
  logic             lockValid;
  logic [IW-1:0]    lockIdx;

  logic [DEPTH-1:0] eligible;
  logic             anyElig, full, empty;
  logic [IW-1:0]    freeIdx, pickIdx;
  logic             entryReq, atomIssue, stFire;

  assign full  = &validVec;
  assign empty = ~|validVec;

  for (genvar i = 0; i < DEPTH; i++) begin : g_elig
    assign eligible[i] = validVec[i] && (groupVec[i] == oldGroup);
  end
  assign anyElig = |eligible;

  // lowest free slot
  always_comb begin
    freeIdx = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (!validVec[i]) freeIdx = IW'(i);
    end
  end

  // rotating pick from a pseudo-random start point
  always_comb begin
    int unsigned startPt;
    int unsigned cand;
    logic found;
    startPt = int'(lfsrQ) % DEPTH;
    pickIdx = '0;
    found   = 1'b0;
    for (int k = 0; k < DEPTH; k++) begin
      cand = (startPt + k) % DEPTH;
      if (!found && eligible[cand]) begin
        pickIdx = IW'(cand);
        found   = 1'b1;
      end
    end
  end

  assign selIdx    = lockValid ? lockIdx : pickIdx;
  assign entryReq  = lockValid || ((atomReq || idleDrainEn) && anyElig);
  assign atomIssue = atomReq && empty && !lockValid;
  assign memValid  = entryReq || atomIssue;
  assign atomDone  = atomIssue && memReady;

  assign stReady = !full && !atomReq;
  assign stFire  = stValid && stReady;
  assign wrIdx   = freeIdx;
  assign wrGroup = curGroup;

  always_comb begin
    strobes         = '0;
    strobes.wrEn    = stFire;
    strobes.clrEn   = entryReq && memReady;
    strobes.atomSel = atomIssue;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      curGroup  <= '0;
      oldGroup  <= '0;
      curUsed   <= 1'b0;
      lfsrQ     <= 16'hACE1;
      lockValid <= 1'b0;
      lockIdx   <= '0;
    end else begin
      // a fence opens a new span only if the current one holds a store
      if (fenceIn && (curUsed || stFire)) begin
        curGroup <= curGroup + 1'b1;
        curUsed  <= 1'b0;
      end else if (stFire) begin
        curUsed <= 1'b1;
      end
      if (!anyElig && oldGroup != curGroup) oldGroup <= oldGroup + 1'b1;
      if (entryReq && memReady) lfsrQ <= lfsrStep(lfsrQ);
      lockValid <= entryReq && !memReady;
      lockIdx   <= selIdx;
    end
  end

  // R5
  span_order_chk: assert property (@(posedge clk) disable iff (!rstN)
    (entryReq && memReady) |-> (groupVec[selIdx] == oldGroup));

endmodule

// File: rtl/fence_store_buffer.sv
module fence_store_buffer
  import sfb_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int AW    = 16,
  parameter int DW    = 32
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          stValid,
  output logic          stReady,
  input  logic [AW-1:0] stAddr,
  input  logic [DW-1:0] stData,
  input  logic          fenceIn,
  input  logic          atomReq,
  input  logic [AW-1:0] atomAddr,
  input  logic [DW-1:0] atomData,
  output logic          atomDone,
  input  logic          idleDrainEn,
  output logic          memValid,
  input  logic          memReady,
  output logic [AW-1:0] memAddr,
  output logic [DW-1:0] memData
);

  localparam int IW = $clog2(DEPTH);
  localparam int GW = $clog2(DEPTH) + 1;

  sfbStrobes_t             strobes;
  logic [IW-1:0]           wrIdx, selIdx;
  logic [GW-1:0]           wrGroup;
  logic [DEPTH-1:0]        validVec;
  logic [DEPTH-1:0][GW-1:0] groupVec;

  sfb_control #(.DEPTH(DEPTH), .IW(IW), .GW(GW)) u_ctrl (
    .clk, .rstN, .stValid, .fenceIn, .atomReq, .idleDrainEn, .memReady,
    .validVec, .groupVec, .stReady, .memValid, .atomDone,
    .strobes, .wrIdx, .wrGroup, .selIdx
  );

  sfb_datapath #(.DEPTH(DEPTH), .AW(AW), .DW(DW), .IW(IW), .GW(GW)) u_dp (
    .clk, .rstN, .strobes, .wrIdx, .wrGroup, .selIdx,
    .stAddr, .stData, .atomAddr, .atomData,
    .validVec, .groupVec, .memAddr, .memData
  );

  // R8
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    (memValid && !memReady && atomReq == !strobes.atomSel ? 1'b0 : (memValid && !memReady))
      |=> (memValid && $stable(memAddr) && $stable(memData)));

  // R3
  quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!idleDrainEn && !atomReq && !$past(memValid)) |-> !memValid);

  // R9
  store_block_chk: assert property (@(posedge clk) disable iff (!rstN)
    atomReq |-> !stReady);

endmodule

// File: tb/fence_store_buffer_bench.sv
module fence_store_buffer_bench;

  localparam int AW = 16;
  localparam int DW = 32;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic stValid = 1'b0, fenceIn = 1'b0, atomReq = 1'b0, idleDrainEn = 1'b0;
  logic memReady = 1'b0;
  logic [AW-1:0] stAddr = '0, atomAddr = '0;
  logic [DW-1:0] stData = '0, atomData = '0;
  logic stReady, atomDone, memValid;
  logic [AW-1:0] memAddr;
  logic [DW-1:0] memData;

  fence_store_buffer u_fence_store_buffer (
    .clk, .rstN, .stValid, .stReady, .stAddr, .stData, .fenceIn,
    .atomReq, .atomAddr, .atomData, .atomDone, .idleDrainEn,
    .memValid, .memReady, .memAddr, .memData
  );

  always #4 clk = ~clk;  // 125 MHz

  int checks = 0, fails = 0;
  bit done = 1'b0;

  logic [AW-1:0] logAddr [64];
  logic [DW-1:0] logData [64];
  int logCnt = 0;
  int stallFails = 0;
  logic [15:0] rdyLfsr = 16'h1D0F;
  bit prevStall = 1'b0;
  logic [AW-1:0] prevAddr;
  logic [DW-1:0] prevData;

  function automatic logic [DW-1:0] mkData(input logic [AW-1:0] a);
    return {16'hC0DE, a};
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // memory model: new ready at negedge, observe handshake 1 ns later
  always @(negedge clk) begin
    rdyLfsr  = {rdyLfsr[14:0], rdyLfsr[15] ^ rdyLfsr[13] ^ rdyLfsr[12] ^ rdyLfsr[10]};
    memReady = rdyLfsr[1:0] != 2'b00;
    #1;
    if (rstN) begin
      if (prevStall && !(memValid && memAddr == prevAddr && memData == prevData))
        stallFails++;
      prevStall = memValid && !memReady;
      prevAddr  = memAddr;
      prevData  = memData;
      if (memValid && memReady && logCnt < 64) begin
        logAddr[logCnt] = memAddr;
        logData[logCnt] = memData;
        logCnt++;
      end
    end
  end

  task automatic pushStore(input logic [AW-1:0] a, input bit withFence);
    @(negedge clk);
    stValid = 1'b1; stAddr = a; stData = mkData(a); fenceIn = withFence;
    #2;
    while (!stReady) begin
      @(negedge clk); #2;
    end
    @(negedge clk);
    stValid = 1'b0; fenceIn = 1'b0;
  endtask

  task automatic pulseFence();
    @(negedge clk); fenceIn = 1'b1;
    @(negedge clk); fenceIn = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // span number lives in address bits [7:4]
  task automatic checkOrder(input string req);
    bit ok = 1'b1;
    for (int i = 0; i < logCnt; i++)
      for (int j = i + 1; j < logCnt; j++)
        if (logAddr[i][7:4] > logAddr[j][7:4]) ok = 1'b0;
    check(ok, req, "span order in write log", ok, 1);
  endtask

  task automatic checkOnce(input logic [AW-1:0] a, input string req);
    int hits = 0;
    bit dataOk = 1'b1;
    for (int i = 0; i < logCnt; i++)
      if (logAddr[i] == a) begin
        hits++;
        if (logData[i] != mkData(a)) dataOk = 1'b0;
      end
    check(hits == 1 && dataOk, req, $sformatf("writes of addr %0h", a), hits, 1);
  endtask

  task automatic runAtomic(input logic [AW-1:0] a, input logic [DW-1:0] d,
                           input string req);
    int waitCnt = 0;
    bit blockOk = 1'b1;
    bit doneOk;
    @(negedge clk);
    atomReq = 1'b1; atomAddr = a; atomData = d;
    #2;
    while (!atomDone && waitCnt < 500) begin
      if (stReady) blockOk = 1'b0;
      @(negedge clk); #2; waitCnt++;
    end
    doneOk = atomDone && memValid && memReady && memAddr == a && memData == d;
    check(blockOk, "R9", "stReady low while atomic pending", !blockOk, 0);
    check(doneOk, "R9", "atomDone with atomic write accepted", doneOk, 1);
    @(negedge clk);
    atomReq = 1'b0;
    #2;
    check(logCnt > 0 && logAddr[logCnt-1] == a, req, "atomic write is last",
          logCnt > 0 ? logAddr[logCnt-1] : 0, a);
  endtask

  task automatic testReset();
    #2;
    check(stReady == 1'b1, "R1", "stReady after reset", stReady, 1);
    check(memValid == 1'b0, "R1", "memValid after reset", memValid, 0);
    check(atomDone == 1'b0, "R1", "atomDone after reset", atomDone, 0);
  endtask

  task automatic testRetainAndFill();
    idleDrainEn = 1'b0;
    logCnt = 0;
    pushStore(16'h0000, 0); pushStore(16'h0001, 0); pushStore(16'h0002, 0);
    pulseFence();
    pushStore(16'h0010, 0); pushStore(16'h0011, 0);
    idle(40);
    check(logCnt == 0, "R3", "writes while retained", logCnt, 0);
    pulseFence(); pulseFence(); pulseFence();
    idle(10);
    check(logCnt == 0, "R4", "writes after bare fences", logCnt, 0);
    pushStore(16'h0020, 0); pushStore(16'h0021, 0); pushStore(16'h0022, 0);
    #2;
    check(stReady == 1'b0, "R2", "stReady with buffer full", stReady, 0);
  endtask

  task automatic testIdleDrain();
    int n = 0;
    @(negedge clk); idleDrainEn = 1'b1;
    while (logCnt < 8 && n < 300) begin @(negedge clk); n++; end
    idle(5);
    check(logCnt == 8, "R7", "writes after idle drain", logCnt, 8);
    #2;
    check(stReady == 1'b1, "R7", "stReady after drain", stReady, 1);
    checkOrder("R5");
    foreach (logAddr[i]) if (i < 3) checkOnce(16'(i), "R6");
    checkOnce(16'h0010, "R6"); checkOnce(16'h0011, "R6");
    checkOnce(16'h0020, "R6"); checkOnce(16'h0021, "R6"); checkOnce(16'h0022, "R6");
    @(negedge clk); idleDrainEn = 1'b0;
  endtask

  task automatic testAtomic();
    logCnt = 0;
    pushStore(16'h0100, 0); pushStore(16'h0101, 0); pushStore(16'h0102, 0);
    pulseFence();
    pushStore(16'h0110, 0); pushStore(16'h0111, 0);
    pulseFence();
    pushStore(16'h0120, 0);
    idle(5);
    check(logCnt == 0, "R3", "no writes before atomic", logCnt, 0);
    runAtomic(16'h00F0, 32'hA70A_0001, "R10");
    check(logCnt == 7, "R10", "writes for atomic drain", logCnt, 7);
    checkOrder("R10");
    checkOnce(16'h0100, "R10"); checkOnce(16'h0120, "R10");
  endtask

  task automatic testSameCycleFence();
    logCnt = 0;
    pushStore(16'h0200, 0); pushStore(16'h0201, 0);
    pushStore(16'h0202, 1);  // R11: store and fence together
    pushStore(16'h0210, 0); pushStore(16'h0211, 0); pushStore(16'h0212, 0);
    runAtomic(16'h02F0, 32'hA70A_0002, "R11");
    checkOrder("R11");
    check(logCnt == 7, "R11", "writes for same-cycle case", logCnt, 7);
    logCnt = 0;
    runAtomic(16'h03F0, 32'hA70A_0003, "R9");
    check(logCnt == 1, "R9", "atomic on empty buffer writes once", logCnt, 1);
  endtask

  initial begin
    idle(4);
    @(negedge clk); rstN = 1'b1;
    testReset();
    testRetainAndFill();
    testIdleDrain();
    testAtomic();
    testSameCycleFence();
    check(stallFails == 0, "R8", "request changed while stalled", stallFails, 0);
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < 100000; i++) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule